// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Datapath

This block executes a small 32-bit load/store instruction subset (register add, subtract, AND, OR, signed set-less-than, word load, word store and branch-if-equal) across five overlapped stages: fetch, decode with register read, execute, memory access and write-back. Four stage registers sit between the stages, and all of them load on the one clock edge. Control is decoded once in the decode stage and travels forward with its instruction. Each group of control bits is dropped after the stage that consumes it.

Instruction memory and data memory sit outside the block on two separate ports, so a fetch never competes with a load or a store. The block has no interlock and no operand forwarding. Software must place a consumer at least three instructions after the producer of its register. The three instructions that follow a taken branch always complete. When the stages are full, one instruction finishes per cycle. The register file's write port is exposed as the completion port.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high at a clock edge, the block clears the program counter to 0 and turns every stage register into a bubble, so after that edge `imem_addr` is 0 and `dmem_we`, `dmem_re` and `wb_we` are low.
- R2: If no branch is taken, `imem_addr` rises by 4 on every clock edge.
- R3: R-type instructions use opcode bits [31:26] = 0, rs in [25:21], rt in [20:16], rd in [15:11] and function code in [5:0]. The function codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than (1 or 0). The result is written to rd.
- R4: An instruction fetched while `imem_addr` = 4k (k cycles after reset release) appears on the completion port exactly four cycles later. Back-to-back instructions therefore complete on consecutive cycles.
- R5: A load (opcode 0x23) reads the word at rs plus the sign-extended 16-bit offset in [15:0]. It raises `dmem_re` with that address in its memory cycle and writes the returned word to rt one cycle later.
- R6: A store (opcode 0x2B) raises `dmem_we` with address rs plus the sign-extended offset and data rt for one cycle. It performs no register write, and the block never raises `dmem_we` and `dmem_re` together.
- R7: A branch (opcode 0x04) compares rs with rt. If they are equal, the fetch address four cycles after the branch was fetched becomes branch address + 4 + (offset << 2), and the three instructions fetched after the branch still complete. If they differ, fetching stays sequential.
- R8: Register 0 reads as zero, and writes to it never appear on the completion port.
- R9: A register written back in a cycle is visible to the decode-stage read in that same cycle.
- R10: Any other opcode acts as a bubble: no register write, no memory access, no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every stage register |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | XLEN | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | XLEN | Data memory byte address for load or store |
| dmem_wdata | output | XLEN | Store data |
| dmem_re | output | 1 | Load in memory stage |
| dmem_we | output | 1 | Store strobe, one cycle |
| dmem_rdata | input | XLEN | Load data at `dmem_addr`, same cycle |
| wb_we | output | 1 | Register write in this cycle (never for register 0) |
| wb_addr | output | log2(NREG) | Destination register being written |
| wb_data | output | XLEN | Value being written |

## Verification
On every cycle, properties check several behaviours: the reset state, the 4-byte fetch step and the redirect to the registered branch target. They also check that a load's returned word reaches the completion port one cycle later, that the store and load strobes never overlap, that unknown opcodes leave a bubble, and that a written register holds its value. The bench shows the rest through whole programs. An exhaustive sweep of all five ALU operations over eight operand values covers signed-compare and overflow corners. Further programs check the exact four-cycle completion timing, write-before-read at the minimum producer distance, negative offsets, store-then-load through data memory, branch shadows and register 0.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int ILEN = 32;

  localparam logic [5:0] OPC_ALU   = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // operation class chosen in decode, refined in execute
  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_FUNCT = 2'd2
  } alu_class_e;

  typedef enum logic [2:0] {
    ALU_NONE = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_AND  = 3'd3,
    ALU_OR   = 3'd4,
    ALU_SLT  = 3'd5
  } alu_sel_e;

  typedef struct packed {
    logic       dst_rd;   // destination is rd, otherwise rt
    alu_class_e cls;
    logic       use_imm;  // second operand is immediate
  } ex_ctrl_t;

  typedef struct packed {
    logic branch;
    logic mem_rd;
    logic mem_wr;
  } mem_ctrl_t;

  typedef struct packed {
    logic reg_wr;
    logic from_mem;
  } wb_ctrl_t;

  typedef struct packed {
    ex_ctrl_t  ex;
    mem_ctrl_t mem;
    wb_ctrl_t  wb;
  } ctrl_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_ALU: begin
        ctrl.ex.dst_rd  = 1'b1;
        ctrl.ex.cls     = CLS_FUNCT;
        ctrl.wb.reg_wr  = 1'b1;
      end
      OPC_LOAD: begin
        ctrl.ex.use_imm  = 1'b1;
        ctrl.ex.cls      = CLS_ADD;
        ctrl.mem.mem_rd  = 1'b1;
        ctrl.wb.reg_wr   = 1'b1;
        ctrl.wb.from_mem = 1'b1;
      end
      OPC_STORE: begin
        ctrl.ex.use_imm = 1'b1;
        ctrl.ex.cls     = CLS_ADD;
        ctrl.mem.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.ex.cls     = CLS_SUB;
        ctrl.mem.branch = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  raddr_a,
  input  logic [RAW-1:0]  raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] regs [NREG];

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  // write-then-read within one cycle: pass the incoming value through
  always_comb begin
    if (raddr_a == '0)                   rdata_a = '0;
    else if (we && waddr == raddr_a)     rdata_a = wdata;
    else                                 rdata_a = regs[raddr_a];
    if (raddr_b == '0)                   rdata_b = '0;
    else if (we && waddr == raddr_b)     rdata_b = wdata;
    else                                 rdata_b = regs[raddr_b];
  end

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_class_e      cls,
  input  logic [5:0]      funct,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  alu_sel_e sel;

  always_comb begin
    case (cls)
      CLS_ADD: sel = ALU_ADD;
      CLS_SUB: sel = ALU_SUB;
      default: begin
        case (funct)
          FN_ADD:  sel = ALU_ADD;
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_SLT:  sel = ALU_SLT;
          default: sel = ALU_NONE;
        endcase
      end
    endcase
  end

  always_comb begin
    case (sel)
      ALU_ADD: result = a + b;
      ALU_SUB: result = a - b;
      ALU_AND: result = a & b;
      ALU_OR:  result = a | b;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [ILEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_re,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            wb_we,
  output logic [RAW-1:0]  wb_addr,
  output logic [XLEN-1:0] wb_data
);

  localparam int IMMW = 16;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [ILEN-1:0] instr;
  } fd_t;

  typedef struct packed {
    ex_ctrl_t        ex;
    mem_ctrl_t       mem;
    wb_ctrl_t        wb;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] imm;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  rd;
  } dx_t;

  typedef struct packed {
    mem_ctrl_t       mem;
    wb_ctrl_t        wb;
    logic            zero;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] store;
    logic [XLEN-1:0] target;
    logic [RAW-1:0]  dest;
  } xm_t;

  typedef struct packed {
    wb_ctrl_t        wb;
    logic [XLEN-1:0] load;
    logic [XLEN-1:0] alu;
    logic [RAW-1:0]  dest;
  } mw_t;

  logic [XLEN-1:0] pc_q;
  fd_t fd_q;
  dx_t dx_q;
  xm_t xm_q;
  mw_t mw_q;

  // ---------------- fetch ----------------
  logic            taken;
  logic [XLEN-1:0] pc_plus4;

  assign taken     = xm_q.mem.branch & xm_q.zero;
  assign pc_plus4  = pc_q + XLEN'(4);
  assign imem_addr = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      fd_q <= '0;
    end else begin
      pc_q <= taken ? xm_q.target : pc_plus4;
      fd_q <= '{pc4: pc_plus4, instr: imem_rdata};
    end
  end

  // ---------------- decode ----------------
  ctrl_t           id_ctrl;
  logic [5:0]      id_opc;
  logic            id_illegal;
  logic [RAW-1:0]  id_rs, id_rt, id_rd;
  logic [XLEN-1:0] id_a, id_b, id_imm;

  assign id_opc = fd_q.instr[31:26];
  assign id_rs  = fd_q.instr[21 +: RAW];
  assign id_rt  = fd_q.instr[16 +: RAW];
  assign id_rd  = fd_q.instr[11 +: RAW];
  assign id_imm = {{(XLEN-IMMW){fd_q.instr[IMMW-1]}}, fd_q.instr[IMMW-1:0]};
  assign id_illegal = !(id_opc inside {OPC_ALU, OPC_LOAD, OPC_STORE, OPC_BEQ});

  pipe5_decode u_decode (
    .opcode (id_opc),
    .ctrl   (id_ctrl)
  );

  logic            rf_we;
  logic [XLEN-1:0] wb_value;

  pipe5_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (mw_q.dest),
    .wdata   (wb_value),
    .raddr_a (id_rs),
    .raddr_b (id_rt),
    .rdata_a (id_a),
    .rdata_b (id_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dx_q <= '0;
    end else begin
      dx_q.ex  <= id_ctrl.ex;
      dx_q.mem <= id_ctrl.mem;
      dx_q.wb  <= id_ctrl.wb;
      dx_q.pc4 <= fd_q.pc4;
      dx_q.opa <= id_a;
      dx_q.opb <= id_b;
      dx_q.imm <= id_imm;
      dx_q.rt  <= id_rt;
      dx_q.rd  <= id_rd;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_b, ex_res;
  logic            ex_zero;

  assign ex_b = dx_q.ex.use_imm ? dx_q.imm : dx_q.opb;

  pipe5_alu #(.XLEN(XLEN)) u_alu (
    .cls    (dx_q.ex.cls),
    .funct  (dx_q.imm[5:0]),
    .a      (dx_q.opa),
    .b      (ex_b),
    .result (ex_res),
    .zero   (ex_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xm_q <= '0;
    end else begin
      xm_q.mem    <= dx_q.mem;
      xm_q.wb     <= dx_q.wb;
      xm_q.zero   <= ex_zero;
      xm_q.alu    <= ex_res;
      xm_q.store  <= dx_q.opb;
      xm_q.target <= dx_q.pc4 + (dx_q.imm << 2);
      xm_q.dest   <= dx_q.ex.dst_rd ? dx_q.rd : dx_q.rt;
    end
  end

  // ---------------- memory ----------------
  assign dmem_addr  = xm_q.alu;
  assign dmem_wdata = xm_q.store;
  assign dmem_re    = xm_q.mem.mem_rd;
  assign dmem_we    = xm_q.mem.mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_q <= '0;
    end else begin
      mw_q.wb   <= xm_q.wb;
      mw_q.load <= dmem_rdata;
      mw_q.alu  <= xm_q.alu;
      mw_q.dest <= xm_q.dest;
    end
  end

  // ---------------- write-back ----------------
  assign wb_value = mw_q.wb.from_mem ? mw_q.load : mw_q.alu;
  assign rf_we    = mw_q.wb.reg_wr && (mw_q.dest != '0);
  assign wb_we    = rf_we;
  assign wb_addr  = mw_q.dest;
  assign wb_data  = wb_value;

  // ---------------- assertions ----------------
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (imem_addr == '0 && !dmem_we && !dmem_re && !wb_we));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !taken |=> imem_addr == $past(imem_addr) + XLEN'(4));

  assert_completes_R4: assert property (@(posedge clk) disable iff (rst)
    (xm_q.wb.reg_wr && xm_q.dest != '0) |=> wb_we);

  assert_load_return_R5: assert property (@(posedge clk) disable iff (rst)
    (dmem_re && xm_q.dest != '0) |=> (wb_we && wb_data == $past(dmem_rdata)));

  assert_mem_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  assert_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    taken |=> imem_addr == $past(xm_q.target));

  assert_illegal_bubble_R10: assert property (@(posedge clk) disable iff (rst)
    id_illegal |=> (dx_q.wb == '0 && dx_q.mem == '0));

endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;

  localparam int MAXC  = 400;
  localparam int IWORDS = 512;
  localparam int DWORDS = 64;
  localparam int WDOG  = 20000;

  localparam logic [5:0] T_LW = 6'h23, T_SW = 6'h2B, T_BEQ = 6'h04;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_re, dmem_we, wb_we;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;

  always #2 clk = ~clk;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // ---------------- memories ----------------
  logic [31:0] imem  [IWORDS];
  logic [31:0] dmem  [DWORDS];
  logic [31:0] dinit [DWORDS];

  assign imem_rdata = imem[imem_addr[10:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DWORDS; i++) dmem[i] <= dinit[i];
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
    end
  end

  // ---------------- expectation tables ----------------
  logic        e_wwe [MAXC];
  logic [4:0]  e_wa  [MAXC];
  logic [31:0] e_wd  [MAXC];
  string       e_wtag[MAXC];
  logic        e_dwe [MAXC];
  logic        e_dre [MAXC];
  logic [31:0] e_da  [MAXC];
  logic [31:0] e_dd  [MAXC];
  string       e_dtag[MAXC];
  logic        e_pcv [MAXC];
  logic [31:0] e_pc  [MAXC];
  string       e_ptag[MAXC];

  int n_chk = 0, n_fail = 0, wd = 0;
  logic [31:0] vals [8];

  always @(posedge clk) begin
    wd++;
    if (wd > WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog: ran %0d cycles, expected under %0d", wd, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [5:0] fn_of(int op);
    case (op)
      0: return 6'h20;
      1: return 6'h22;
      2: return 6'h24;
      3: return 6'h25;
      default: return 6'h2A;
    endcase
  endfunction

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic clear_all();
    for (int i = 0; i < IWORDS; i++) imem[i] = 32'h0;
    for (int i = 0; i < DWORDS; i++) dinit[i] = 32'h0;
    for (int c = 0; c < MAXC; c++) begin
      e_wwe[c] = 1'b0; e_wa[c] = '0; e_wd[c] = '0; e_wtag[c] = "R4";
      e_dwe[c] = 1'b0; e_dre[c] = 1'b0; e_da[c] = '0; e_dd[c] = '0; e_dtag[c] = "R6";
      e_pcv[c] = 1'b0; e_pc[c] = '0; e_ptag[c] = "R2";
    end
  endtask

  task automatic put_wb(int c, int a, logic [31:0] d, string tag);
    e_wwe[c] = 1'b1; e_wa[c] = 5'(a); e_wd[c] = d; e_wtag[c] = tag;
  endtask

  task automatic put_pc(int c, logic [31:0] pc, string tag);
    e_pcv[c] = 1'b1; e_pc[c] = pc; e_ptag[c] = tag;
  endtask

  task automatic put_st(int c, logic [31:0] a, logic [31:0] d, string tag);
    e_dwe[c] = 1'b1; e_da[c] = a; e_dd[c] = d; e_dtag[c] = tag;
  endtask

  task automatic put_ld(int c, logic [31:0] a, string tag);
    e_dre[c] = 1'b1; e_da[c] = a; e_dtag[c] = tag;
  endtask

  task automatic run_prog(int ncyc);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 32'h0, "R1", "reset fetch address", imem_addr, 32'h0);
    chk(!wb_we,   "R1", "reset wb_we",   {31'h0, wb_we},   32'h0);
    chk(!dmem_we, "R1", "reset dmem_we", {31'h0, dmem_we}, 32'h0);
    chk(!dmem_re, "R1", "reset dmem_re", {31'h0, dmem_re}, 32'h0);
    rst = 1'b0;
    for (int c = 1; c <= ncyc; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk(wb_we == e_wwe[c], e_wtag[c], "wb_we", {31'h0, wb_we}, {31'h0, e_wwe[c]});
      if (e_wwe[c] && wb_we) begin
        chk(wb_addr == e_wa[c], e_wtag[c], "wb_addr", {27'h0, wb_addr}, {27'h0, e_wa[c]});
        chk(wb_data == e_wd[c], e_wtag[c], "wb_data", wb_data, e_wd[c]);
      end
      chk(dmem_we == e_dwe[c], e_dtag[c], "dmem_we", {31'h0, dmem_we}, {31'h0, e_dwe[c]});
      chk(dmem_re == e_dre[c], e_dtag[c], "dmem_re", {31'h0, dmem_re}, {31'h0, e_dre[c]});
      if (e_dwe[c] || e_dre[c])
        chk(dmem_addr == e_da[c], e_dtag[c], "dmem_addr", dmem_addr, e_da[c]);
      if (e_dwe[c])
        chk(dmem_wdata == e_dd[c], e_dtag[c], "dmem_wdata", dmem_wdata, e_dd[c]);
      if (e_pcv[c])
        chk(imem_addr == e_pc[c], e_ptag[c], "imem_addr", imem_addr, e_pc[c]);
    end
  endtask

  initial begin
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFFFFFF;
    vals[3] = 32'h7FFFFFFF; vals[4] = 32'h80000000; vals[5] = 32'h5;
    vals[6] = 32'h12345678; vals[7] = 32'hF0F0F0F0;

    // ---- Program A: ALU sweep, R2 R3 R4 ----
    begin
      int idx;
      clear_all();
      for (int k = 0; k < 8; k++) begin
        dinit[k] = vals[k];
        imem[k]  = enc_i(T_LW, 0, k + 1, 4 * k);
        put_ld(k + 3, 32'(4 * k), "R5");
        put_wb(k + 4, k + 1, vals[k], "R4");
      end
      idx = 8;
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int op = 0; op < 5; op++) begin
            int rd;
            rd = 9 + (idx % 23);
            imem[idx] = enc_r(a + 1, b + 1, rd, fn_of(op));
            put_wb(idx + 4, rd, model(op, vals[a], vals[b]), "R3");
            idx++;
          end
      for (int c = 1; c <= idx + 6; c++) put_pc(c, 32'(4 * c), "R2");
      run_prog(idx + 6);
    end

    // ---- Program B: loads, stores, r0, bypass, illegal ----
    clear_all();
    dinit[0] = 32'h11111111; dinit[1] = 32'h22222222; dinit[2] = 32'h40;
    imem[0]  = enc_i(T_LW, 0, 1, 0);
    imem[1]  = enc_i(T_LW, 0, 2, 4);
    imem[2]  = enc_i(T_LW, 0, 3, 8);
    imem[3]  = enc_r(1, 1, 0, 6'h20);         // write to register 0
    imem[4]  = enc_r(1, 2, 4, 6'h20);         // reads r2 in its write-back cycle
    imem[5]  = enc_r(0, 1, 5, 6'h22);         // r0 as source
    imem[6]  = enc_i(6'h3F, 1, 6, 16'h1234);  // unknown opcode
    imem[7]  = enc_i(6'h08, 0, 7, 5);         // unknown opcode
    imem[8]  = enc_i(T_SW, 0, 4, 12);
    imem[9]  = enc_i(T_SW, 3, 5, -8);
    imem[10] = enc_i(T_LW, 0, 6, 12);
    imem[11] = enc_i(T_LW, 3, 7, -8);
    imem[12] = enc_i(T_SW, 0, 0, 16);
    put_ld(3, 32'd0, "R5");  put_wb(4, 1, 32'h11111111, "R5");
    put_ld(4, 32'd4, "R5");  put_wb(5, 2, 32'h22222222, "R5");
    put_ld(5, 32'd8, "R5");  put_wb(6, 3, 32'h40, "R5");
    e_wtag[7] = "R8";
    put_wb(8, 4, 32'h33333333, "R9");
    put_wb(9, 5, 32'hEEEEEEEF, "R8");
    e_wtag[10] = "R10"; e_wtag[11] = "R10";
    e_dtag[9]  = "R10"; e_dtag[10] = "R10";
    put_st(11, 32'd12, 32'h33333333, "R6"); e_wtag[12] = "R6";
    put_st(12, 32'd56, 32'hEEEEEEEF, "R6"); e_wtag[13] = "R6";
    put_ld(13, 32'd12, "R5"); put_wb(14, 6, 32'h33333333, "R5");
    put_ld(14, 32'd56, "R5"); put_wb(15, 7, 32'hEEEEEEEF, "R5");
    put_st(15, 32'd16, 32'h0, "R8");
    for (int c = 1; c <= 20; c++) put_pc(c, 32'(4 * c), "R2");
    run_prog(20);

    // ---- Program C: branches, R7 ----
    clear_all();
    dinit[0] = 32'd7; dinit[1] = 32'd7; dinit[2] = 32'd9;
    imem[0]  = enc_i(T_LW, 0, 1, 0);
    imem[1]  = enc_i(T_LW, 0, 2, 4);
    imem[2]  = enc_i(T_LW, 0, 3, 8);
    imem[5]  = enc_i(T_BEQ, 1, 2, 6);      // taken, target 48
    imem[6]  = enc_r(1, 2, 10, 6'h20);
    imem[7]  = enc_r(1, 3, 11, 6'h25);
    imem[8]  = enc_r(1, 3, 12, 6'h24);
    imem[9]  = enc_r(1, 1, 20, 6'h20);     // skipped
    imem[10] = enc_r(1, 1, 20, 6'h20);     // skipped
    imem[11] = enc_r(1, 1, 20, 6'h20);     // skipped
    imem[12] = enc_i(T_BEQ, 1, 3, 10);     // not taken
    imem[13] = enc_r(3, 3, 14, 6'h20);
    imem[14] = enc_i(T_BEQ, 0, 0, 5);      // taken, target 80
    imem[15] = enc_r(3, 1, 15, 6'h22);
    imem[16] = enc_r(1, 3, 16, 6'h2A);
    imem[17] = enc_r(3, 1, 17, 6'h2A);
    imem[18] = enc_r(1, 1, 21, 6'h20);     // skipped
    imem[19] = enc_r(1, 1, 21, 6'h20);     // skipped
    imem[20] = enc_r(3, 3, 18, 6'h20);
    put_wb(4, 1, 32'd7, "R5"); put_wb(5, 2, 32'd7, "R5"); put_wb(6, 3, 32'd9, "R5");
    put_ld(3, 32'd0, "R5"); put_ld(4, 32'd4, "R5"); put_ld(5, 32'd8, "R5");
    e_wtag[9] = "R7";
    put_wb(10, 10, 32'd14, "R7");
    put_wb(11, 11, 32'd15, "R7");
    put_wb(12, 12, 32'd1,  "R7");
    e_wtag[13] = "R7";
    put_wb(14, 14, 32'd18, "R7");
    e_wtag[15] = "R7";
    put_wb(16, 15, 32'd2,  "R7");
    put_wb(17, 16, 32'd1,  "R3");
    put_wb(18, 17, 32'd0,  "R3");
    put_wb(19, 18, 32'd18, "R7");
    for (int c = 20; c <= 26; c++) e_wtag[c] = "R7";
    for (int c = 1;  c <= 8;  c++) put_pc(c, 32'(4 * c), "R2");
    for (int c = 9;  c <= 14; c++) put_pc(c, 32'(48 + 4 * (c - 9)), "R7");
    for (int c = 15; c <= 26; c++) put_pc(c, 32'(80 + 4 * (c - 15)), "R7");
    run_prog(26);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule